// File: doc/BRIEF.md
# SPI master shift engine

This block is the serial core of an SPI master. It accepts one parallel word on a transmit handshake and shifts it out on `mosi`, one bit per serial clock period. At the same time it samples `miso` and returns the assembled word on a receive strobe. The word is 1 to 32 bits long. The serial clock comes from a 16-bit reload timer. Clock polarity, clock phase, bit order, the idle level of the data line and loopback are all static configuration inputs. The transmitter and the receiver can each be switched off independently. A FIFO, a register front end or a chip-select generator sits around the block and drives these ports.

A three-state machine controls the engine:

- `ST_IDLE` waits for a word.
- `ST_SHIFT` produces the serial clock edges.
- `ST_DONE` lasts one cycle and presents the received word.

The transitions are:

- `ST_IDLE -> ST_SHIFT` on a transmit handshake.
- `ST_SHIFT -> ST_DONE` on the timer tick that makes the final clock edge of the frame.
- `ST_DONE -> ST_IDLE` unconditionally.

In receive-only mode the transmit handshake is still the frame request. The word is accepted and discarded.

Top module: `spi_shift_master`

## Requirements
- R1: `cfg_len_m1` holds the word length minus one. A frame has N = `cfg_len_m1`+1 bits and exactly 2N serial clock edges. `rx_data` carries the N received bits right-aligned, with zeros above them.
- R2: Every serial clock half-period, and the delay from frame start to the first edge, lasts `cfg_reload`+1 clock cycles.
- R3: `sclk` rests at `cfg_pol` between frames.
  - With `cfg_ph`=1 (clock phase 0), the first bit is on `mosi` before the first edge. Data is sampled on leading edges and changes on trailing edges.
  - With `cfg_ph`=0 (clock phase 1), data is driven on leading edges and sampled on trailing edges.
- R4: With `cfg_msb_first`=1, bit N-1 goes first. With `cfg_msb_first`=0, bit 0 goes first. The same order applies to assembling the received word.
- R5: `mosi` equals `cfg_idle_val` whenever no frame is shifting.
- R6: With `cfg_tx_off`=1 and the receiver on, frames still run on a transmit handshake, and `mosi` stays at `cfg_idle_val` throughout.
- R7: With `cfg_rx_off`=1, `rx_valid` never pulses. Transmission still runs.
- R8: With both `cfg_tx_off` and `cfg_rx_off` set, `tx_ready` stays low and no frame starts.
- R9: A frame starts only on a transmit handshake (`tx_valid` and `tx_ready`). Without one, `sclk` does not move.
- R10: `busy` rises on the cycle after the handshake and stays high for exactly 2N(`cfg_reload`+1) cycles. `tx_ready` is low while busy and during the following cycle. `rx_valid` is a single-cycle pulse on the cycle after `busy` falls.
- R11: With `cfg_loopback`=1, the receiver samples the engine's own `mosi` and ignores `miso`.
- R12: During and right after reset, `busy` and `rx_valid` are low, `sclk` equals `cfg_pol`, `mosi` equals `cfg_idle_val`, and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_reload | input | 16 | Baud timer reload value |
| cfg_pol | input | 1 | Serial clock rest level |
| cfg_ph | input | 1 | Phase select, inverse of clock phase |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_idle_val | input | 1 | Level on `mosi` when not shifting |
| cfg_tx_off | input | 1 | Transmitter switched off |
| cfg_rx_off | input | 1 | Receiver switched off |
| cfg_loopback | input | 1 | Route `mosi` back to the receiver |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can accept a word |
| tx_data | input | 32 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that every configuration input holds still while a frame is shifting and during its completion cycle. The properties on the idle `sclk` level, on the receive strobe and on the both-off case would otherwise see legitimate changes. The bench applies a new configuration only after `busy` has fallen and the completion cycle has passed, and it then waits two cycles before offering a word. It also releases `tx_valid` right after each handshake, so every frame it checks starts from a single offered word.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } shift_state_e;

endpackage

// File: rtl/spi_baud_timer.sv
module spi_baud_timer #(
    parameter int BR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [BR_W-1:0] reload,
    output logic            tick
);

    logic [BR_W-1:0] cnt_q;
    logic            at_end;

    assign at_end = (cnt_q == reload);
    assign tick   = run && at_end;

    // Counter restarts from zero whenever the engine is not shifting,
    // so the first edge comes reload+1 cycles after a frame begins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msb_first,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              pop,
    input  logic              cap,
    input  logic              cap_bit,
    output logic              head,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [LEN_W-1:0]  align;

    // Distance between the top of the register and the top bit of the word.
    assign align = LEN_W'(WORD_W - 1) - len_m1;

    assign head    = msb_first ? tx_sr[WORD_W-1] : tx_sr[0];
    assign rx_word = msb_first ? rx_sr : (rx_sr >> align);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= msb_first ? (load_word << align) : load_word;
        end else if (pop) begin
            tx_sr <= msb_first ? (tx_sr << 1) : (tx_sr >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (load) begin
            rx_sr <= '0;
        end else if (cap) begin
            if (msb_first) begin
                rx_sr <= {rx_sr[WORD_W-2:0], cap_bit};
            end else begin
                rx_sr <= {cap_bit, rx_sr[WORD_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_shift_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BR_W   = 16,
    localparam int LEN_W  = $clog2(WORD_W),
    localparam int EDGE_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic [BR_W-1:0]   cfg_reload,
    input  logic              cfg_pol,
    input  logic              cfg_ph,
    input  logic              cfg_msb_first,
    input  logic              cfg_idle_val,
    input  logic              cfg_tx_off,
    input  logic              cfg_rx_off,
    input  logic              cfg_loopback,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WORD_W-1:0] tx_data,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);

    shift_state_e      state_q, state_d;
    logic [EDGE_W-1:0] edge_q;
    logic              sclk_q;
    logic              drive_q;

    logic cpha;
    logic tick;
    logic start;
    logic last_edge;
    logic sample_edge;
    logic drive_edge;
    logic pop;
    logic cap;
    logic rx_bit;
    logic tx_head;

    // The phase input is the inverse of the conventional clock phase.
    assign cpha        = ~cfg_ph;
    assign start       = tx_valid && tx_ready;
    assign last_edge   = (edge_q == {cfg_len_m1, 1'b1});
    assign sample_edge = tick && (edge_q[0] == cpha);
    assign drive_edge  = tick && (edge_q[0] != cpha);
    assign cap         = sample_edge && !cfg_rx_off;
    assign rx_bit      = cfg_loopback ? mosi : miso;

    // Phase 0: the first bit is already on the line, so every non-final
    // trailing edge advances. Phase 1: the first leading edge only enables
    // the line, and later leading edges advance.
    assign pop = drive_edge && !last_edge && (!cpha || (edge_q != '0));

    spi_baud_timer #(
        .BR_W (BR_W)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_SHIFT),
        .reload (cfg_reload),
        .tick   (tick)
    );

    spi_word_shifter #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .msb_first (cfg_msb_first),
        .len_m1    (cfg_len_m1),
        .load      (start),
        .load_word (tx_data),
        .pop       (pop),
        .cap       (cap),
        .cap_bit   (rx_bit),
        .head      (tx_head),
        .rx_word   (rx_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Edge counter, serial clock and line-enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q  <= '0;
            sclk_q  <= 1'b0;
            drive_q <= 1'b0;
        end else if (start) begin
            edge_q  <= '0;
            sclk_q  <= cfg_pol;
            drive_q <= !cpha;
        end else if ((state_q == ST_SHIFT) && tick) begin
            edge_q <= edge_q + 1'b1;
            sclk_q <= ~sclk_q;
            if (last_edge) begin
                drive_q <= 1'b0;
            end else if (cpha && (edge_q == '0)) begin
                drive_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        tx_ready = 1'b0;
        busy     = 1'b0;
        rx_valid = 1'b0;
        sclk     = cfg_pol;
        mosi     = cfg_idle_val;
        unique case (state_q)
            ST_IDLE: begin
                tx_ready = !(cfg_tx_off && cfg_rx_off);
            end
            ST_SHIFT: begin
                busy = 1'b1;
                sclk = sclk_q;
                if (drive_q && !cfg_tx_off) begin
                    mosi = tx_head;
                end
            end
            ST_DONE: begin
                rx_valid = !cfg_rx_off;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_pol,
    input logic cfg_idle_val,
    input logic cfg_tx_off,
    input logic cfg_rx_off,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic busy,
    input logic sclk,
    input logic mosi
);

    p_ready_low_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_ready);

    p_rx_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $fell(busy));

    p_rx_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rx_off |-> !rx_valid);

    p_mosi_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mosi == cfg_idle_val));

    p_txoff_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tx_off |-> (mosi == cfg_idle_val));

    p_start_on_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_valid && tx_ready));

    p_both_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_off && cfg_rx_off && !busy) |=> !busy);

    p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(cfg_pol)) |-> $stable(sclk));

endmodule

bind spi_shift_master spi_shift_master_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_pol      (cfg_pol),
    .cfg_idle_val (cfg_idle_val),
    .cfg_tx_off   (cfg_tx_off),
    .cfg_rx_off   (cfg_rx_off),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_valid     (rx_valid),
    .busy         (busy),
    .sclk         (sclk),
    .mosi         (mosi)
);

// File: tb/spi_shift_master_tb_top.sv
module spi_shift_master_tb_top;

    typedef struct packed {
        logic [4:0]  len_m1;
        logic [15:0] br;
        logic        pol;
        logic        ph;
        logic        msb;
        logic        idle;
        logic        txoff;
        logic        rxoff;
        logic        loop;
        logic [31:0] txw;
        logic [31:0] slw;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'd7,  16'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h000000A5, 32'h0000003C},
        '{5'd7,  16'd2,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000096, 32'h0000005A},
        '{5'd15, 16'd1,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00001234, 32'h0000BEEF},
        '{5'd31, 16'd0,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h13579BDF},
        '{5'd0,  16'd5,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFE},
        '{5'd11, 16'd3,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000ABC, 32'h000005A5},
        '{5'd9,  16'd1,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h000002C3, 32'h00000155},
        '{5'd23, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00C0FFEE, 32'h00000000},
        '{5'd4,  16'd300, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000015, 32'h0000000A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_len_m1 = 5'd7;
    logic [15:0] cfg_reload = 16'd0;
    logic        cfg_pol = 1'b1;
    logic        cfg_ph = 1'b1;
    logic        cfg_msb_first = 1'b1;
    logic        cfg_idle_val = 1'b1;
    logic        cfg_tx_off = 1'b0;
    logic        cfg_rx_off = 1'b0;
    logic        cfg_loopback = 1'b0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] tx_data = '0;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_shift_master dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_len_m1    (cfg_len_m1),
        .cfg_reload    (cfg_reload),
        .cfg_pol       (cfg_pol),
        .cfg_ph        (cfg_ph),
        .cfg_msb_first (cfg_msb_first),
        .cfg_idle_val  (cfg_idle_val),
        .cfg_tx_off    (cfg_tx_off),
        .cfg_rx_off    (cfg_rx_off),
        .cfg_loopback  (cfg_loopback),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_data       (tx_data),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .sclk          (sclk),
        .mosi          (mosi),
        .miso          (miso),
        .busy          (busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic bitsel(input logic [31:0] w, input logic msb, input int n, input int k);
        return msb ? w[n-1-k] : w[k];
    endfunction

    task automatic apply_cfg(input vec_t v);
        @(negedge clk);
        cfg_len_m1    = v.len_m1;
        cfg_reload    = v.br;
        cfg_pol       = v.pol;
        cfg_ph        = v.ph;
        cfg_msb_first = v.msb;
        cfg_idle_val  = v.idle;
        cfg_tx_off    = v.txoff;
        cfg_rx_off    = v.rxoff;
        cfg_loopback  = v.loop;
    endtask

    task automatic run_vec(input vec_t v);
        int          n;
        int          k_out;
        int          cap_k;
        int          edges;
        int          busy_cyc;
        int          cyc;
        int          last_k;
        int          rx_seen;
        int          tail;
        int          guard;
        bit          gap_ok;
        bit          ready_ok;
        bit          seen_busy;
        logic        cpha;
        logic        leading;
        logic        sclk_prev;
        logic        mosi_prev;
        logic [31:0] mask;
        logic [31:0] exp_rx;
        logic [31:0] exp_tx;
        logic [31:0] cap_w;
        logic [31:0] rx_got;

        n = int'(v.len_m1) + 1;
        cpha = ~v.ph;
        mask = 32'((64'd1 << n) - 64'd1);
        k_out = 0; cap_k = 0; edges = 0; busy_cyc = 0; cyc = 0; last_k = 1;
        rx_seen = 0; tail = 0; guard = 0;
        gap_ok = 1'b1; ready_ok = 1'b1; seen_busy = 1'b0;
        cap_w = '0; rx_got = '0;

        apply_cfg(v);
        repeat (2) @(negedge clk);
        chk(sclk == v.pol && mosi == v.idle, "R5 rest levels before frame",
            {sclk, mosi}, {v.pol, v.idle});
        chk(tx_ready == 1'b1, "R10 ready while idle", tx_ready, 1);

        if (!cpha) begin
            miso = bitsel(v.slw, v.msb, n, 0);
            k_out = 1;
        end else begin
            miso = 1'b0;
        end
        tx_data = v.txw;
        tx_valid = 1'b1;
        sclk_prev = sclk;
        mosi_prev = mosi;

        while (tail < 3 && guard < 150000) begin
            @(negedge clk);
            guard++;
            cyc++;
            if (cyc == 1) tx_valid = 1'b0;
            if (busy) begin
                seen_busy = 1'b1;
                busy_cyc++;
                if (tx_ready) ready_ok = 1'b0;
            end
            if (rx_valid) begin
                rx_seen++;
                rx_got = rx_data;
                if (busy || tx_ready) ready_ok = 1'b0;
            end
            if (sclk !== sclk_prev) begin
                edges++;
                if (cyc - last_k != int'(v.br) + 1) gap_ok = 1'b0;
                last_k = cyc;
                leading = (sclk != v.pol);
                if (leading != cpha) begin
                    if (cap_k < 32) cap_w[cap_k] = mosi_prev;
                    cap_k++;
                end else begin
                    if (k_out < n) miso = bitsel(v.slw, v.msb, n, k_out);
                    k_out++;
                end
            end
            if (seen_busy && !busy) tail++;
            sclk_prev = sclk;
            mosi_prev = mosi;
        end

        exp_tx = '0;
        for (int i = 0; i < n; i++) begin
            exp_tx[i] = v.txoff ? v.idle : bitsel(v.txw, v.msb, n, i);
        end
        exp_rx = (v.loop ? v.txw : v.slw) & mask;

        chk(busy_cyc == 2 * n * (int'(v.br) + 1), "R10 busy length",
            busy_cyc, 2 * n * (int'(v.br) + 1));
        chk(edges == 2 * n, "R1 serial edge count", edges, 2 * n);
        chk(gap_ok, "R2 half-period length", gap_ok, 1);
        chk(ready_ok, "R10 ready low while busy or completing", ready_ok, 1);
        if (v.txoff) begin
            chk((cap_w & mask) == exp_tx, "R6 line held idle with transmitter off", cap_w & mask, exp_tx);
        end else begin
            chk((cap_w & mask) == exp_tx, "R4 transmitted bit order and R3 sampling", cap_w & mask, exp_tx);
        end
        if (v.rxoff) begin
            chk(rx_seen == 0, "R7 no receive strobe with receiver off", rx_seen, 0);
        end else begin
            chk(rx_seen == 1, "R10 one receive strobe", rx_seen, 1);
            if (v.loop) begin
                chk(rx_got == exp_rx, "R11 loopback word", rx_got, exp_rx);
            end else begin
                chk(rx_got == exp_rx, "R1 received word alignment and order", rx_got, exp_rx);
            end
        end
        chk(sclk == v.pol && mosi == v.idle, "R3 rest levels after frame",
            {sclk, mosi}, {v.pol, v.idle});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        bit quiet_ok;
        bit off_ok;
        vec_t v;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && rx_valid == 1'b0, "R12 busy and strobe low in reset",
            {busy, rx_valid}, 0);
        chk(sclk == 1'b1 && mosi == 1'b1, "R12 clock and line at configured rest",
            {sclk, mosi}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1 && busy == 1'b0, "R12 ready after reset", {tx_ready, busy}, 2'b10);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R9: no word offered, clock and line stay put
        v = VECS[1];
        apply_cfg(v);
        tx_valid = 1'b0;
        quiet_ok = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (busy || sclk != v.pol || mosi != v.idle) quiet_ok = 1'b0;
        end
        chk(quiet_ok, "R9 clock idle without a word", quiet_ok, 1);

        // R8: both directions off, offered word is never taken
        @(negedge clk);
        cfg_tx_off = 1'b1;
        cfg_rx_off = 1'b1;
        tx_valid = 1'b1;
        off_ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (tx_ready || busy || rx_valid || sclk != v.pol) off_ok = 1'b0;
        end
        tx_valid = 1'b0;
        chk(off_ok, "R8 no frame with both directions off", off_ok, 1);

        // Recovery after both-off
        run_vec(VECS[0]);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule